// File: doc/BRIEF.md
# Regime-Tagged TLB Invalidation Matcher

This block is the tag side of a small fully associative translation cache. Each slot holds a valid bit, a translation regime (non-secure guest, secure, secure monitor, hypervisor or E2H), a VMID, an ASID, a global flag, a virtual page number and a last-level flag. An allocation port writes a new tag into the lowest free slot. An invalidation port takes an opcode with optional VA, ASID and VMID operands. In a single clock it clears every valid slot that the opcode's rule selects, and it reports completion with a one-cycle done pulse.

Matching depends on the regime. Hypervisor slots carry no ASID or VMID and belong to one owner. E2H slots have no security tag and use the ASID only when they are non-global. Per-context-bank commands issued for an E2H bank select E2H slots instead of comparing the VMID. Monitor slots have their own invalidate-all, by-VA and last-level-only commands, and these leave ordinary secure slots alone. A global mode input selects whether hypervisor or E2H tags may be allocated, and the two kinds are never valid at the same time.

Top module: `regime_tlb_inval`

## Requirements
- R1: After reset, entryValid is all zero, cmdReady is 1, and cmdDone, allocOk and allocErr are 0.
- R2: Regime codes on allocRegime are 0 guest, 1 secure, 2 monitor, 3 hypervisor and 4 E2H. An allocation request that is accepted writes the lowest-numbered free slot and raises allocOk for one cycle after its clock edge. A request made when every slot is valid, or with a code above 4, raises allocErr instead and leaves entryValid unchanged.
- R3: A hypervisor (code 3) allocation is rejected with allocErr when e2hMode is 1 or when any E2H slot is valid. An E2H (code 4) allocation is rejected when e2hMode is 0 or when any hypervisor slot is valid.
- R4: A command is accepted on a clock edge where cmdValid and cmdReady are both 1. Its slots are cleared at that edge. cmdDone is 1 for exactly the following cycle, and cmdReady is 0 during that cycle.
- R5: Opcode 1 (hypervisor all) clears every hypervisor slot and every E2H slot and no other slot.
- R6: Opcode 2 (hypervisor by VA, serving both address widths) clears hypervisor slots whose VPN matches. It also clears E2H slots whose VPN matches and that are either global or have a matching ASID. Opcode 3 applies the same rule but only to slots marked last-level.
- R7: Opcodes 4, 5 and 6 (monitor all, monitor by VA, monitor by VA last-level) clear only monitor slots, selected by all, by VPN match, and by VPN match with the last-level flag set, in that order. Secure slots stay valid.
- R8: Opcode 0 (all non-secure non-hypervisor) clears guest and E2H slots. It leaves secure, monitor and hypervisor slots valid.
- R9: Opcode 7 (secure all) clears secure slots only. Opcode 8 (by VMID) clears guest slots whose VMID matches. Neither opcode clears an E2H slot, even when the VMID of that slot matches.
- R10: When cmdE2h is 0, the per-context-bank opcodes select guest slots with a matching VMID. Opcode 9 clears all of them. Opcode 10 clears the non-global ones with a matching ASID. Opcode 11 clears those with a matching VPN that are either global or have a matching ASID.
- R11: When cmdE2h is 1, opcodes 9, 10 and 11 apply the same rules to E2H slots, with the VMID ignored. Guest slots are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| e2hMode | input | 1 | 1 selects E2H tagging, 0 selects hypervisor tagging |
| allocValid | input | 1 | Allocation request |
| allocRegime | input | 3 | Regime code of the new slot |
| allocVmid | input | VMID_W | VMID of the new slot |
| allocAsid | input | ASID_W | ASID of the new slot |
| allocGlobal | input | 1 | Global flag of the new slot |
| allocVpn | input | VPN_W | Virtual page number of the new slot |
| allocLast | input | 1 | Last-level flag of the new slot |
| allocOk | output | 1 | Previous allocation accepted |
| allocErr | output | 1 | Previous allocation rejected |
| cmdValid | input | 1 | Invalidation command present |
| cmdOp | input | 4 | Invalidation opcode |
| cmdE2h | input | 1 | Per-context-bank command issued for an E2H bank |
| cmdVmid | input | VMID_W | VMID operand |
| cmdAsid | input | ASID_W | ASID operand |
| cmdVpn | input | VPN_W | VPN operand |
| cmdReady | output | 1 | A command can be accepted |
| cmdDone | output | 1 | One-cycle completion pulse |
| entryValid | output | ENTRIES | Valid bit of each slot |

## Verification
The bench drives every stimulus half a cycle before a rising edge and reads the outputs half a cycle after that edge. allocOk and allocErr are due in the first sample after the request edge. The cleared entryValid mask, the high cmdDone and the low cmdReady are also due in that first sample after the command edge. The bench reads cmdDone and cmdReady once more in the sample after that, to confirm that the pulse has ended and a new command can be accepted.

// File: rtl/tim_pkg.sv
package tim_pkg;
  typedef enum logic [2:0] {
    RG_GUEST = 3'd0,
    RG_SEC   = 3'd1,
    RG_MON   = 3'd2,
    RG_HYP   = 3'd3,
    RG_E2H   = 3'd4
  } regime_e;

  typedef enum logic [3:0] {
    OP_ALL_NSNH = 4'd0,
    OP_HYP_ALL  = 4'd1,
    OP_HYP_VA   = 4'd2,
    OP_HYP_VAL  = 4'd3,
    OP_MON_ALL  = 4'd4,
    OP_MON_VA   = 4'd5,
    OP_MON_VAL  = 4'd6,
    OP_SEC_ALL  = 4'd7,
    OP_VMID_ALL = 4'd8,
    OP_CB_ALL   = 4'd9,
    OP_CB_ASID  = 4'd10,
    OP_CB_VA    = 4'd11
  } invOp_e;

  typedef struct packed {
    logic   doInv;
    logic   e2hBank;
    invOp_e op;
    logic   doAlloc;
  } strobe_t;
endpackage

// File: rtl/tim_ctrl.sv
module tim_ctrl
  import tim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        e2hMode,
  input  logic        cmdValid,
  input  logic [3:0]  cmdOp,
  input  logic        cmdE2h,
  input  logic        allocValid,
  input  logic [2:0]  allocRegime,
  input  logic        anyHyp,
  input  logic        anyE2h,
  input  logic        full,
  output strobe_t     strobe,
  output logic        cmdReady,
  output logic        cmdDone,
  output logic        allocOk,
  output logic        allocErr
);
  logic wantHyp, wantE2h, badCode, conflict, allowAlloc;

  // A new command waits until the done pulse of the previous one has been issued
  assign cmdReady = !cmdDone;

  assign wantHyp  = (allocRegime == RG_HYP);
  assign wantE2h  = (allocRegime == RG_E2H);
  assign badCode  = (allocRegime > RG_E2H);
  assign conflict = (wantHyp && (e2hMode || anyE2h)) ||
                    (wantE2h && (!e2hMode || anyHyp));
  assign allowAlloc = allocValid && !full && !conflict && !badCode;

  always_comb begin
    strobe.doInv   = cmdValid && cmdReady;
    strobe.e2hBank = cmdE2h;
    strobe.op      = invOp_e'(cmdOp);
    strobe.doAlloc = allowAlloc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdDone  <= 1'b0;
      allocOk  <= 1'b0;
      allocErr <= 1'b0;
    end else begin
      cmdDone  <= strobe.doInv;
      allocOk  <= allowAlloc;
      allocErr <= allocValid && !allowAlloc;
    end
  end
endmodule

// File: rtl/tim_store.sv
module tim_store
  import tim_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VMID_W  = 8,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [VMID_W-1:0] cmdVmid,
  input  logic [ASID_W-1:0] cmdAsid,
  input  logic [VPN_W-1:0]  cmdVpn,
  input  logic [2:0]        allocRegime,
  input  logic [VMID_W-1:0] allocVmid,
  input  logic [ASID_W-1:0] allocAsid,
  input  logic              allocGlobal,
  input  logic [VPN_W-1:0]  allocVpn,
  input  logic              allocLast,
  output logic [ENTRIES-1:0] entryValid,
  output logic              anyHyp,
  output logic              anyE2h,
  output logic              full
);
  logic [ENTRIES-1:0] hit, freeOh, hypVec, e2hVec;

  always_comb begin
    logic found;
    found  = 1'b0;
    freeOh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!entryValid[i] && !found) begin
        freeOh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign full   = &entryValid;
  assign anyHyp = |hypVec;
  assign anyE2h = |e2hVec;

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic              v;
    logic [2:0]        rg;
    logic [VMID_W-1:0] vmid;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [VPN_W-1:0]  vpn;
    logic              last;
    logic              sel;
    logic isG, isS, isM, isH, isE, vaHit, asidHit, vmidHit, gOrAsid, cbTarget;

    assign isG     = (rg == RG_GUEST);
    assign isS     = (rg == RG_SEC);
    assign isM     = (rg == RG_MON);
    assign isH     = (rg == RG_HYP);
    assign isE     = (rg == RG_E2H);
    assign vaHit   = (vpn == cmdVpn);
    assign asidHit = (asid == cmdAsid);
    assign vmidHit = (vmid == cmdVmid);
    assign gOrAsid = glob || asidHit;
    // Context-bank commands from an E2H bank select on the E2H tag, not on VMID
    assign cbTarget = strobe.e2hBank ? isE : (isG && vmidHit);

    always_comb begin
      unique case (strobe.op)
        OP_ALL_NSNH: sel = isG || isE;
        OP_HYP_ALL:  sel = isH || isE;
        OP_HYP_VA:   sel = vaHit && (isH || (isE && gOrAsid));
        OP_HYP_VAL:  sel = vaHit && last && (isH || (isE && gOrAsid));
        OP_MON_ALL:  sel = isM;
        OP_MON_VA:   sel = isM && vaHit;
        OP_MON_VAL:  sel = isM && vaHit && last;
        OP_SEC_ALL:  sel = isS;
        OP_VMID_ALL: sel = isG && vmidHit;
        OP_CB_ALL:   sel = cbTarget;
        OP_CB_ASID:  sel = cbTarget && !glob && asidHit;
        OP_CB_VA:    sel = cbTarget && vaHit && gOrAsid;
        default:     sel = 1'b0;
      endcase
    end

    assign hit[g]        = v && sel;
    assign entryValid[g] = v;
    assign hypVec[g]     = v && isH;
    assign e2hVec[g]     = v && isE;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        v <= 1'b0;
      end else if (strobe.doAlloc && freeOh[g]) begin
        v <= 1'b1;
      end else if (strobe.doInv && hit[g]) begin
        v <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.doAlloc && freeOh[g]) begin
        rg   <= allocRegime;
        vmid <= allocVmid;
        asid <= allocAsid;
        glob <= allocGlobal;
        vpn  <= allocVpn;
        last <= allocLast;
      end
    end
  end
endmodule

// File: rtl/regime_tlb_inval.sv
module regime_tlb_inval
  import tim_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VMID_W  = 8,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               e2hMode,
  input  logic               allocValid,
  input  logic [2:0]         allocRegime,
  input  logic [VMID_W-1:0]  allocVmid,
  input  logic [ASID_W-1:0]  allocAsid,
  input  logic               allocGlobal,
  input  logic [VPN_W-1:0]   allocVpn,
  input  logic               allocLast,
  output logic               allocOk,
  output logic               allocErr,
  input  logic               cmdValid,
  input  logic [3:0]         cmdOp,
  input  logic               cmdE2h,
  input  logic [VMID_W-1:0]  cmdVmid,
  input  logic [ASID_W-1:0]  cmdAsid,
  input  logic [VPN_W-1:0]   cmdVpn,
  output logic               cmdReady,
  output logic               cmdDone,
  output logic [ENTRIES-1:0] entryValid
);
  strobe_t strobe;
  logic    anyHyp, anyE2h, full;

  tim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .e2hMode(e2hMode),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdE2h(cmdE2h),
    .allocValid(allocValid), .allocRegime(allocRegime),
    .anyHyp(anyHyp), .anyE2h(anyE2h), .full(full),
    .strobe(strobe), .cmdReady(cmdReady), .cmdDone(cmdDone),
    .allocOk(allocOk), .allocErr(allocErr)
  );

  tim_store #(
    .ENTRIES(ENTRIES), .VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdVmid(cmdVmid), .cmdAsid(cmdAsid), .cmdVpn(cmdVpn),
    .allocRegime(allocRegime), .allocVmid(allocVmid), .allocAsid(allocAsid),
    .allocGlobal(allocGlobal), .allocVpn(allocVpn), .allocLast(allocLast),
    .entryValid(entryValid), .anyHyp(anyHyp), .anyE2h(anyE2h), .full(full)
  );
endmodule

// File: rtl/regime_tlb_inval_chk.sv
module regime_tlb_inval_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               e2hMode,
  input logic               allocValid,
  input logic [2:0]         allocRegime,
  input logic               allocOk,
  input logic               allocErr,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic               cmdDone,
  input logic [ENTRIES-1:0] entryValid,
  input logic               anyHyp,
  input logic               anyE2h
);
  assert_done_next_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> cmdDone);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  assert_alloc_answer_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |=> (allocOk ^ allocErr));

  assert_grow_only_alloc_R2: assert property (@(posedge clk) disable iff (!rstN)
    !allocOk |-> ($countones(entryValid) <= $countones($past(entryValid))));

  assert_tags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(anyHyp && anyE2h));

  assert_hyp_in_e2h_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocRegime == 3'd3 && e2hMode) |=> allocErr);
endmodule

bind regime_tlb_inval regime_tlb_inval_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .e2hMode(e2hMode),
  .allocValid(allocValid), .allocRegime(allocRegime),
  .allocOk(allocOk), .allocErr(allocErr),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdDone(cmdDone),
  .entryValid(entryValid), .anyHyp(anyHyp), .anyE2h(anyE2h)
);

// File: tb/sim_regime_tlb_inval.sv
`timescale 1ns/1ps
module sim_regime_tlb_inval;
  logic        clk = 1'b0;
  logic        rstN;
  logic        e2hMode;
  logic        allocValid;
  logic [2:0]  allocRegime;
  logic [7:0]  allocVmid, allocAsid;
  logic        allocGlobal;
  logic [19:0] allocVpn;
  logic        allocLast;
  logic        allocOk, allocErr;
  logic        cmdValid;
  logic [3:0]  cmdOp;
  logic        cmdE2h;
  logic [7:0]  cmdVmid, cmdAsid;
  logic [19:0] cmdVpn;
  logic        cmdReady, cmdDone;
  logic [15:0] entryValid;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  regime_tlb_inval u0 (
    .clk(clk), .rstN(rstN), .e2hMode(e2hMode),
    .allocValid(allocValid), .allocRegime(allocRegime), .allocVmid(allocVmid),
    .allocAsid(allocAsid), .allocGlobal(allocGlobal), .allocVpn(allocVpn),
    .allocLast(allocLast), .allocOk(allocOk), .allocErr(allocErr),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdE2h(cmdE2h), .cmdVmid(cmdVmid),
    .cmdAsid(cmdAsid), .cmdVpn(cmdVpn), .cmdReady(cmdReady), .cmdDone(cmdDone),
    .entryValid(entryValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit mode);
    rstN = 0; e2hMode = mode; allocValid = 0; allocRegime = 0; allocVmid = 0;
    allocAsid = 0; allocGlobal = 0; allocVpn = 0; allocLast = 0;
    cmdValid = 0; cmdOp = 0; cmdE2h = 0; cmdVmid = 0; cmdAsid = 0; cmdVpn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic alloc(input logic [2:0] rg, input logic [7:0] vmid, input logic [7:0] asid,
                       input bit g, input logic [19:0] vpn, input bit last,
                       input bit expOk, input string req);
    @(negedge clk);
    allocValid = 1; allocRegime = rg; allocVmid = vmid; allocAsid = asid;
    allocGlobal = g; allocVpn = vpn; allocLast = last;
    @(negedge clk);
    allocValid = 0;
    check({req, " allocOk"}, 32'(allocOk), 32'(expOk));
    check({req, " allocErr"}, 32'(allocErr), 32'(!expOk));
  endtask

  task automatic inv(input logic [3:0] op, input bit e2h, input logic [7:0] vmid,
                     input logic [7:0] asid, input logic [19:0] vpn,
                     input logic [15:0] expMask, input string req);
    @(negedge clk);
    check("R4 ready before command", 32'(cmdReady), 32'd1);
    cmdValid = 1; cmdOp = op; cmdE2h = e2h; cmdVmid = vmid; cmdAsid = asid; cmdVpn = vpn;
    @(negedge clk);
    cmdValid = 0;
    check("R4 done pulse", 32'(cmdDone), 32'd1);
    check("R4 ready low during done", 32'(cmdReady), 32'd0);
    check({req, " mask"}, 32'(entryValid), 32'(expMask));
    @(negedge clk);
    check("R4 done ends", 32'(cmdDone), 32'd0);
    check("R4 ready returns", 32'(cmdReady), 32'd1);
  endtask

  task automatic testReset();
    doReset(0);
    check("R1 entryValid", 32'(entryValid), 32'd0);
    check("R1 cmdReady", 32'(cmdReady), 32'd1);
    check("R1 cmdDone", 32'(cmdDone), 32'd0);
    check("R1 allocOk", 32'(allocOk), 32'd0);
    check("R1 allocErr", 32'(allocErr), 32'd0);
  endtask

  task automatic testFill();
    doReset(0);
    for (int i = 0; i < 16; i++) begin
      alloc(3'd0, 8'(i), 8'd1, 0, 20'd1, 0, 1, "R2 fill");
      check("R2 lowest slot", 32'(entryValid), (32'd1 << (i + 1)) - 1);
    end
    alloc(3'd0, 8'd0, 8'd0, 0, 20'd0, 0, 0, "R2 full");
    check("R2 full unchanged", 32'(entryValid), 32'hFFFF);
    inv(4'd8, 0, 8'd5, 8'd0, 20'd0, 16'hFFDF, "R9 vmid in fill");
    alloc(3'd1, 8'd0, 8'd0, 0, 20'd0, 0, 1, "R2 reuse");
    check("R2 reuse slot5", 32'(entryValid), 32'hFFFF);
    doReset(0);
    alloc(3'd5, 8'd0, 8'd0, 0, 20'd0, 0, 0, "R2 bad code");
    check("R2 bad code unchanged", 32'(entryValid), 32'd0);
  endtask

  task automatic testMode();
    doReset(0);
    alloc(3'd4, 8'd0, 8'd0, 0, 20'd0, 0, 0, "R3 e2h in hyp mode");
    alloc(3'd3, 8'd0, 8'd0, 0, 20'd0, 0, 1, "R3 hyp in hyp mode");
    e2hMode = 1;
    alloc(3'd4, 8'd0, 8'd0, 0, 20'd0, 0, 0, "R3 e2h while hyp valid");
    alloc(3'd3, 8'd0, 8'd0, 0, 20'd0, 0, 0, "R3 hyp in e2h mode");
    check("R3 mask after rejects", 32'(entryValid), 32'd1);
    inv(4'd1, 0, 8'd0, 8'd0, 20'd0, 16'h0, "R5 flush hyp");
    alloc(3'd4, 8'd0, 8'd0, 0, 20'd0, 0, 1, "R3 e2h after flush");
    e2hMode = 0;
    alloc(3'd3, 8'd0, 8'd0, 0, 20'd0, 0, 0, "R3 hyp while e2h valid");
    check("R3 final mask", 32'(entryValid), 32'd1);
  endtask

  task automatic testHyp();
    doReset(0);
    alloc(3'd3, 8'd0, 8'd0, 0, 20'd5, 1, 1, "R6 setup");
    alloc(3'd3, 8'd0, 8'd0, 0, 20'd6, 0, 1, "R6 setup");
    alloc(3'd1, 8'd0, 8'd0, 0, 20'd5, 1, 1, "R6 setup");
    alloc(3'd2, 8'd0, 8'd0, 0, 20'd5, 1, 1, "R6 setup");
    alloc(3'd0, 8'd1, 8'd0, 0, 20'd5, 1, 1, "R6 setup");
    inv(4'd2, 0, 8'd0, 8'd0, 20'd5, 16'h1E, "R6 hyp by VA");
    inv(4'd3, 0, 8'd0, 8'd0, 20'd6, 16'h1E, "R6 hyp last-level skips non-last");
    inv(4'd1, 0, 8'd0, 8'd0, 20'd0, 16'h1C, "R5 hyp all");
  endtask

  task automatic testE2h();
    doReset(1);
    alloc(3'd4, 8'd2, 8'd3, 1, 20'd7, 1, 1, "R6 setup");
    alloc(3'd4, 8'd2, 8'd3, 0, 20'd7, 1, 1, "R6 setup");
    alloc(3'd4, 8'd2, 8'd4, 0, 20'd7, 1, 1, "R6 setup");
    alloc(3'd0, 8'd2, 8'd3, 0, 20'd7, 1, 1, "R6 setup");
    alloc(3'd1, 8'd2, 8'd3, 0, 20'd7, 1, 1, "R6 setup");
    alloc(3'd2, 8'd2, 8'd3, 0, 20'd7, 1, 1, "R6 setup");
    inv(4'd3, 0, 8'd0, 8'd3, 20'd7, 16'h3C, "R6 hyp last-level on e2h global or asid");
    inv(4'd8, 0, 8'd2, 8'd0, 20'd0, 16'h34, "R9 vmid spares e2h");
    inv(4'd7, 0, 8'd0, 8'd0, 20'd0, 16'h24, "R9 secure all spares e2h");
    inv(4'd0, 0, 8'd0, 8'd0, 20'd0, 16'h20, "R8 nsnh clears e2h keeps monitor");
  endtask

  task automatic testNsnh();
    doReset(0);
    alloc(3'd0, 8'd1, 8'd1, 0, 20'd1, 0, 1, "R8 setup");
    alloc(3'd1, 8'd1, 8'd1, 0, 20'd1, 0, 1, "R8 setup");
    alloc(3'd2, 8'd1, 8'd1, 0, 20'd1, 0, 1, "R8 setup");
    alloc(3'd3, 8'd1, 8'd1, 0, 20'd1, 0, 1, "R8 setup");
    inv(4'd0, 0, 8'd0, 8'd0, 20'd0, 16'hE, "R8 nsnh keeps secure monitor hyp");
  endtask

  task automatic testMon();
    doReset(0);
    alloc(3'd2, 8'd0, 8'd0, 0, 20'd9, 1, 1, "R7 setup");
    alloc(3'd2, 8'd0, 8'd0, 0, 20'd9, 0, 1, "R7 setup");
    alloc(3'd2, 8'd0, 8'd0, 0, 20'd10, 1, 1, "R7 setup");
    alloc(3'd1, 8'd0, 8'd0, 0, 20'd9, 1, 1, "R7 setup");
    alloc(3'd0, 8'd0, 8'd0, 0, 20'd9, 1, 1, "R7 setup");
    inv(4'd6, 0, 8'd0, 8'd0, 20'd9, 16'h1E, "R7 monitor last-level");
    inv(4'd5, 0, 8'd0, 8'd0, 20'd9, 16'h1C, "R7 monitor by VA");
    inv(4'd4, 0, 8'd0, 8'd0, 20'd0, 16'h18, "R7 monitor all keeps secure");
  endtask

  task automatic testCbGuest();
    doReset(0);
    alloc(3'd0, 8'd1, 8'd1, 0, 20'd3, 0, 1, "R10 setup");
    alloc(3'd0, 8'd1, 8'd2, 0, 20'd3, 0, 1, "R10 setup");
    alloc(3'd0, 8'd1, 8'd9, 1, 20'd3, 0, 1, "R10 setup");
    alloc(3'd0, 8'd2, 8'd1, 0, 20'd3, 0, 1, "R10 setup");
    alloc(3'd1, 8'd1, 8'd1, 0, 20'd3, 0, 1, "R10 setup");
    inv(4'd11, 0, 8'd1, 8'd1, 20'd3, 16'h1A, "R10 cb by VA with global");
    inv(4'd10, 0, 8'd1, 8'd2, 20'd0, 16'h18, "R10 cb by ASID");
    inv(4'd9, 0, 8'd2, 8'd0, 20'd0, 16'h10, "R10 cb all by vmid");
  endtask

  task automatic testCbE2h();
    doReset(1);
    alloc(3'd4, 8'd5, 8'd1, 0, 20'd4, 0, 1, "R11 setup");
    alloc(3'd4, 8'd5, 8'd2, 0, 20'd4, 0, 1, "R11 setup");
    alloc(3'd4, 8'd5, 8'd7, 1, 20'd4, 0, 1, "R11 setup");
    alloc(3'd0, 8'd5, 8'd1, 0, 20'd4, 0, 1, "R11 setup");
    inv(4'd11, 1, 8'd9, 8'd1, 20'd4, 16'hA, "R11 e2h cb by VA");
    inv(4'd10, 1, 8'd9, 8'd2, 20'd0, 16'h8, "R11 e2h cb by ASID");
    inv(4'd9, 1, 8'd5, 8'd0, 20'd0, 16'h8, "R11 e2h cb all spares guest");
    inv(4'd9, 0, 8'd5, 8'd0, 20'd0, 16'h0, "R10 guest cb all");
  endtask

  initial begin
    testReset();
    testFill();
    testMode();
    testHyp();
    testE2h();
    testNsnh();
    testMon();
    testCbGuest();
    testCbE2h();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule